// File: doc/BRIEF.md
# Snooping MSI Coherence Line Controller

This block tracks the coherence state of every line in one private, direct-mapped cache that shares a snooping bus with other caches. Each line is in one of three states. Invalid holds nothing usable. Shared is clean and may be read locally with no bus traffic. Modified is dirty and may be read or written locally with no bus traffic. The block keeps a state and a tag for each line. It decides for itself whether a local access hits.

For each local read or write, the block chooses the bus request to issue: a read miss, a write miss or an invalidate. When a miss displaces a dirty line, it also raises an eviction copy-back. The block also watches bus transactions from other caches: read miss, write miss and invalidate. When one of these matches a line, the block downgrades that line. If the matched line is dirty, it raises a flush copy-back. Data storage, memory and bus arbitration live elsewhere. All outputs are registered single-cycle pulses that carry block-aligned addresses.

Top module: `msi_line_ctrl`

## Requirements
- R1: After synchronous active-low reset, every line is Invalid. All output pulses are low until a request arrives.
- R2: An address splits into three fields. Bits [OFF_W-1:0] are the byte offset. The next IDX_W bits are the line index. The remaining upper bits are the tag. A local read that does not match a valid line issues a read miss (command 2'b01) on the bus, addressed to the block (offset zeroed). The line then holds the new tag in Shared.
- R3: A local write that does not match a valid line issues a write miss (command 2'b10) and leaves the line Modified. A local write that matches a Shared line issues an invalidate (command 2'b11) and leaves the line Modified.
- R4: A read that matches a Shared or Modified line, and a write that matches a Modified line, issue no bus request and keep the state.
- R5: A local miss to a line that holds a different tag in Modified raises an eviction with the old block address, in the same cycle as the miss request. A miss to a clean or Invalid line raises no eviction.
- R6: A snooped write miss (2'b10) or invalidate (2'b11) that matches a Shared line makes it Invalid, with no flush.
- R7: A snooped read miss (2'b01) that matches a Modified line raises a flush with the block address and leaves the line Shared. A snooped read miss on a Shared line changes nothing.
- R8: A snooped write miss that matches a Modified line raises a flush and leaves the line Invalid.
- R9: A snooped transaction affects a line only when both the index and the tag match. Any other snoop leaves the line unchanged.
- R10: When a local request and a snoop arrive in the same cycle, the snoop is applied first. The local request is then judged against the updated state.
- R11: A snooped invalidate that matches a Modified line is ignored: there is no flush and the line stays Modified.
- R12: Responses appear in the cycle after the request edge and last one cycle. cpu_rsp_valid marks each local request. cpu_rsp_hit reports whether the line held the tag in a valid state after any same-cycle snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Local access this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Local access address |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | 01 read miss, 10 write miss, 11 invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| cpu_rsp_valid | output | 1 | Response pulse for a local access |
| cpu_rsp_hit | output | 1 | Line held the address in a valid state |
| bus_req_valid | output | 1 | Bus request pulse |
| bus_req_cmd | output | 2 | Bus command, same encoding as snp_cmd |
| bus_req_addr | output | ADDR_W | Block address of the bus request |
| evict_valid | output | 1 | Copy-back of a displaced dirty line |
| evict_addr | output | ADDR_W | Block address being evicted |
| flush_valid | output | 1 | Copy-back forced by a snoop |
| flush_addr | output | ADDR_W | Block address being flushed |

## Verification
The hardest situation to reach is a snoop and a local access to the same line in the same cycle. The outcome must show that the snoop was applied first: a read to a Modified line turns into a miss without an eviction, or a write turns into an invalidate alongside a flush. The stimulus first drives a line into a known state through a chain of local accesses and single snoops. It then presents both inputs in one cycle and checks the local request pulse and the flush pulse together. A variant with different indices confirms that a flush and a local miss can coexist.

// File: rtl/msi_pkg.sv
// Package: shared encodings for the MSI line controller.
// Assumes a 2-bit state and a 2-bit bus command field.
package msi_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_RDMISS = 2'b01,
        CMD_WRMISS = 2'b10,
        CMD_INVAL  = 2'b11
    } bus_cmd_e;
endpackage

// File: rtl/msi_line_array.sv
// Line array: state and tag per line, two combinational read ports
// and two write ports. Port B (local, state+tag) wins over port A
// (snoop, state only) when both address the same line, because the
// local result is already computed from the post-snoop state.
module msi_line_array
    import msi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_state_e      ra_state,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output line_state_e      rb_state,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  line_state_e      wa_state,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  line_state_e      wb_state,
    input  logic [TAG_W-1:0] wb_tag
);
    localparam int LINES = 1 << IDX_W;

    line_state_e      state_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];

    genvar gi;
    generate
        for (gi = 0; gi < LINES; gi++) begin : g_line
            // Per-line state register: reset to Invalid, local write first.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    state_q[gi] <= ST_INV;
                else if (wb_en && wb_idx == IDX_W'(gi))
                    state_q[gi] <= wb_state;
                else if (wa_en && wa_idx == IDX_W'(gi))
                    state_q[gi] <= wa_state;
            end

            // Per-line tag register: only local allocation changes it.
            always_ff @(posedge clk) begin
                if (wb_en && wb_idx == IDX_W'(gi))
                    tag_q[gi] <= wb_tag;
            end

            // Encoding guard: the unused state code never appears.
            assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
                state_q[gi] != line_state_e'(2'b11));
        end
    endgenerate

    // Read ports: plain lookups.
    always_comb begin
        ra_state = state_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        rb_state = state_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
    end
endmodule

// File: rtl/msi_snoop_eval.sv
// Snoop evaluator: applies a transaction seen on the bus to the
// addressed line. Assumes the line's stored state and tag are given.
// Output upd requests a state write, flush requests a copy-back.
module msi_snoop_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_state_e      cur_state,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             upd,
    output line_state_e      nxt_state,
    output logic             flush
);
    logic match;

    // Next-state rule for a line seen by another cache's transaction.
    always_comb begin
        match     = snp_valid && cur_state != ST_INV && cur_tag == snp_tag;
        upd       = 1'b0;
        nxt_state = cur_state;
        flush     = 1'b0;
        if (match) begin
            unique case (bus_cmd_e'(snp_cmd))
                CMD_RDMISS: if (cur_state == ST_MOD) begin
                    upd = 1'b1; nxt_state = ST_SHR; flush = 1'b1;
                end
                CMD_WRMISS: begin
                    upd = 1'b1; nxt_state = ST_INV; flush = (cur_state == ST_MOD);
                end
                CMD_INVAL: if (cur_state == ST_SHR) begin
                    upd = 1'b1; nxt_state = ST_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_local_eval.sv
// Local evaluator: judges a processor access against the line state
// (already updated by any same-cycle snoop) and picks the bus command,
// the new state and whether a dirty victim must be evicted.
module msi_local_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    input  line_state_e      cur_state,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             hit,
    output logic             upd,
    output line_state_e      nxt_state,
    output logic [1:0]       cmd,
    output logic             evict
);
    // Processor-side transition rule.
    always_comb begin
        hit       = cur_state != ST_INV && cur_tag == req_tag;
        upd       = 1'b0;
        nxt_state = cur_state;
        cmd       = CMD_NONE;
        evict     = 1'b0;
        if (req_valid) begin
            if (!hit) begin
                upd       = 1'b1;
                nxt_state = req_write ? ST_MOD : ST_SHR;
                cmd       = req_write ? CMD_WRMISS : CMD_RDMISS;
                evict     = (cur_state == ST_MOD);
            end else if (req_write && cur_state == ST_SHR) begin
                upd       = 1'b1;
                nxt_state = ST_MOD;
                cmd       = CMD_INVAL;
            end
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
// Top: MSI coherence line controller for a direct-mapped private cache.
// Snoop is applied first, then the local access sees the updated line.
// All outputs are registered, one-cycle pulses with block addresses.
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_hit,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    line_state_e      s_cur, c_raw, c_post, s_nxt, c_nxt;
    logic [TAG_W-1:0] s_cur_tag, c_cur_tag;
    logic             s_upd, s_flush, c_hit, c_upd, c_evict;
    logic [1:0]       c_cmd;
    logic             unused_offsets;

    assign c_idx = cpu_addr[OFF_W +: IDX_W];
    assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign s_idx = snp_addr[OFF_W +: IDX_W];
    assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

    msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (s_idx),
        .ra_state (s_cur),
        .ra_tag   (s_cur_tag),
        .rb_idx   (c_idx),
        .rb_state (c_raw),
        .rb_tag   (c_cur_tag),
        .wa_en    (s_upd),
        .wa_idx   (s_idx),
        .wa_state (s_nxt),
        .wb_en    (c_upd),
        .wb_idx   (c_idx),
        .wb_state (c_nxt),
        .wb_tag   (c_tag)
    );

    msi_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_tag   (s_tag),
        .cur_state (s_cur),
        .cur_tag   (s_cur_tag),
        .upd       (s_upd),
        .nxt_state (s_nxt),
        .flush     (s_flush)
    );

    // Forward the snoop's result to the local path when both hit one line.
    always_comb begin
        c_post = (s_upd && s_idx == c_idx) ? s_nxt : c_raw;
    end

    msi_local_eval #(.TAG_W(TAG_W)) u_local (
        .req_valid (cpu_req_valid),
        .req_write (cpu_req_write),
        .req_tag   (c_tag),
        .cur_state (c_post),
        .cur_tag   (c_cur_tag),
        .hit       (c_hit),
        .upd       (c_upd),
        .nxt_state (c_nxt),
        .cmd       (c_cmd),
        .evict     (c_evict)
    );

    // Output registers: one-cycle pulses carrying block-aligned addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_hit   <= 1'b0;
            bus_req_valid <= 1'b0;
            bus_req_cmd   <= CMD_NONE;
            bus_req_addr  <= '0;
            evict_valid   <= 1'b0;
            evict_addr    <= '0;
            flush_valid   <= 1'b0;
            flush_addr    <= '0;
        end else begin
            cpu_rsp_valid <= cpu_req_valid;
            cpu_rsp_hit   <= cpu_req_valid && c_hit;
            bus_req_valid <= c_cmd != CMD_NONE;
            bus_req_cmd   <= c_cmd;
            bus_req_addr  <= {c_tag, c_idx, {OFF_W{1'b0}}};
            evict_valid   <= c_evict;
            evict_addr    <= {c_cur_tag, c_idx, {OFF_W{1'b0}}};
            flush_valid   <= s_flush;
            flush_addr    <= {s_tag, s_idx, {OFF_W{1'b0}}};
        end
    end

    assert_inval_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == CMD_INVAL) |-> cpu_rsp_hit);

    assert_evict_with_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (bus_req_valid && bus_req_cmd != CMD_INVAL && !cpu_rsp_hit));

    assert_flush_from_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ($past(snp_valid) && $past(snp_cmd) != CMD_INVAL));

    assert_req_from_cpu_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (cpu_rsp_valid && $past(cpu_req_valid)));

    assert_pulse_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !cpu_req_valid) |=> !bus_req_valid);
endmodule

// File: tb/msi_line_ctrl_test.sv
`timescale 1ns/1ps
module msi_line_ctrl_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic          cpu_rsp_valid, cpu_rsp_hit, bus_req_valid, evict_valid, flush_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr, evict_addr, flush_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [1:0] RD = 2'b01, WR = 2'b10, IV = 2'b11, NO = 2'b00;
    localparam logic [AW-1:0] A = 32'h0001_2034, B = 32'h0004_5038, C = 32'h0007_8030;
    localparam logic [AW-1:0] D = 32'h000A_B050;
    localparam logic [AW-1:0] C_OTHER_TAG = 32'h0099_9030, C_OTHER_IDX = 32'h0007_8040;

    always #10 clk = ~clk;

    msi_line_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_addr(cpu_addr),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    task automatic chk(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs settle by the next one.
    task automatic step(logic cv, logic cw, logic [AW-1:0] ca,
                        logic sv, logic [1:0] sc, logic [AW-1:0] sa);
        cpu_req_valid = cv; cpu_req_write = cw; cpu_addr = ca;
        snp_valid = sv; snp_cmd = sc; snp_addr = sa;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0; snp_valid = 1'b0; snp_cmd = NO;
    endtask

    function automatic logic [AW-1:0] blk(logic [AW-1:0] a);
        return {a[AW-1:4], 4'h0};
    endfunction

    // Compare every output against the expected pulse set; addresses only when valid.
    task automatic expect_out(string req, logic rv, logic hit, logic [1:0] bc,
                              logic [AW-1:0] ba, logic ev, logic [AW-1:0] ea,
                              logic fv, logic [AW-1:0] fa);
        chk(req, "cpu_rsp_valid", AW'(cpu_rsp_valid), AW'(rv));
        if (rv) chk(req, "cpu_rsp_hit", AW'(cpu_rsp_hit), AW'(hit));
        chk(req, "bus_req_valid", AW'(bus_req_valid), AW'(bc != NO));
        if (bc != NO) begin
            chk(req, "bus_req_cmd", AW'(bus_req_cmd), AW'(bc));
            chk(req, "bus_req_addr", bus_req_addr, blk(ba));
        end
        chk(req, "evict_valid", AW'(evict_valid), AW'(ev));
        if (ev) chk(req, "evict_addr", evict_addr, blk(ea));
        chk(req, "flush_valid", AW'(flush_valid), AW'(fv));
        if (fv) chk(req, "flush_addr", flush_addr, blk(fa));
    endtask

    task automatic t_reset_and_read_miss();
        step(0, 0, '0, 0, NO, '0);
        expect_out("R1", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 0, A, 0, NO, '0);                      // R2: first read misses
        expect_out("R2", 1, 0, RD, A, 0, '0, 0, '0);
    endtask

    task automatic t_hits_and_upgrade();
        step(1, 0, A, 0, NO, '0);
        expect_out("R4", 1, 1, NO, '0, 0, '0, 0, '0);
        step(1, 1, A, 0, NO, '0);                      // R3: write to Shared invalidates
        expect_out("R3", 1, 1, IV, A, 0, '0, 0, '0);
        step(1, 1, A, 0, NO, '0);
        expect_out("R4", 1, 1, NO, '0, 0, '0, 0, '0);
        step(1, 0, A, 0, NO, '0);
        expect_out("R4", 1, 1, NO, '0, 0, '0, 0, '0);
    endtask

    task automatic t_replacement();
        step(1, 0, B, 0, NO, '0);                      // R5: dirty A evicted
        expect_out("R5", 1, 0, RD, B, 1, A, 0, '0);
        step(1, 1, C, 0, NO, '0);                      // R3/R5: clean victim, write miss
        expect_out("R3", 1, 0, WR, C, 0, '0, 0, '0);
    endtask

    task automatic t_snoop_read();
        step(0, 0, '0, 1, RD, C);                      // R7: flush, down to Shared
        expect_out("R7", 0, 0, NO, '0, 0, '0, 1, C);
        step(1, 0, C, 0, NO, '0);
        expect_out("R7", 1, 1, NO, '0, 0, '0, 0, '0);
        step(0, 0, '0, 1, RD, C);                      // R7: Shared ignores read miss
        expect_out("R7", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 1, C, 0, NO, '0);
        expect_out("R7", 1, 1, IV, C, 0, '0, 0, '0);
    endtask

    task automatic t_snoop_write_and_inval();
        step(0, 0, '0, 1, WR, C);                      // R8: flush, to Invalid
        expect_out("R8", 0, 0, NO, '0, 0, '0, 1, C);
        step(1, 0, C, 0, NO, '0);
        expect_out("R8", 1, 0, RD, C, 0, '0, 0, '0);
        step(0, 0, '0, 1, WR, C);                      // R6: Shared to Invalid, no flush
        expect_out("R6", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 0, C, 0, NO, '0);
        expect_out("R6", 1, 0, RD, C, 0, '0, 0, '0);
        step(0, 0, '0, 1, IV, C);                      // R6: invalidate on Shared
        expect_out("R6", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 1, C, 0, NO, '0);
        expect_out("R6", 1, 0, WR, C, 0, '0, 0, '0);
    endtask

    task automatic t_partial_match();
        step(0, 0, '0, 1, RD, C_OTHER_TAG);            // R9: index matches, tag differs
        expect_out("R9", 0, 0, NO, '0, 0, '0, 0, '0);
        step(0, 0, '0, 1, WR, C_OTHER_IDX);            // R9: tag matches, index differs
        expect_out("R9", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 1, C, 0, NO, '0);
        expect_out("R9", 1, 1, NO, '0, 0, '0, 0, '0);
    endtask

    task automatic t_inval_on_modified();
        step(0, 0, '0, 1, IV, C);                      // R11: ignored on Modified
        expect_out("R11", 0, 0, NO, '0, 0, '0, 0, '0);
        step(1, 1, C, 0, NO, '0);
        expect_out("R11", 1, 1, NO, '0, 0, '0, 0, '0);
    endtask

    task automatic t_same_cycle();
        step(1, 0, C, 1, WR, C);                       // R10: snoop invalidates first
        expect_out("R10", 1, 0, RD, C, 0, '0, 1, C);
        step(1, 1, C, 0, NO, '0);                      // Shared -> Modified
        expect_out("R10", 1, 1, IV, C, 0, '0, 0, '0);
        step(1, 1, C, 1, RD, C);                       // R10: flush then upgrade
        expect_out("R10", 1, 1, IV, C, 0, '0, 1, C);
        step(1, 0, D, 1, WR, C);                       // R10: distinct lines, both act
        expect_out("R10", 1, 0, RD, D, 0, '0, 1, C);
    endtask

    task automatic t_pulses();
        step(1, 1, D, 0, NO, '0);
        expect_out("R12", 1, 1, IV, D, 0, '0, 0, '0);
        step(0, 0, '0, 0, NO, '0);                     // R12: pulses last one cycle
        expect_out("R12", 0, 0, NO, '0, 0, '0, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_read_miss();
        t_hits_and_upgrade();
        t_replacement();
        t_snoop_read();
        t_snoop_write_and_inval();
        t_partial_match();
        t_inval_on_modified();
        t_same_cycle();
        t_pulses();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule